// File: doc/BRIEF.md
# Codec Indexed Control Register Interface

This block is the host-facing register front end of an audio codec. The host sees four byte-wide ports, selected by a 2-bit address. One port holds a pointer. A second port reads and writes whichever of 16 or 32 internal 8-bit control registers that pointer selects. The remaining two ports are an interrupt status byte and a programmed-I/O data byte. Each indirect register comes out of reset with a fixed default. Writes follow per-register rules: some registers drop writes, some have only part of their bits writable, and the rate/format register accepts a write only while mode-change is enabled.

An interrupt level is driven out of the block. The playback DMA engine raises it through a one-cycle set input, and the host clears it through the status port or through the alternate status register. The rate/format, interface, pin and playback count registers are brought out as plain outputs for the format decoder and the DMA counter. Those two blocks sit beside this one.

Top module: `codec_regif`

## Requirements
- R1: Address 0 is the pointer port. It resets to 0x40. A write stores bits 6:0, and bit 7 always reads as 0. Bit 6 is the mode-change-enable flag (MCE).
- R2: Address 1 accesses indirect register number = pointer bits 3:0 while bit 6 of register 12 is 0. When that bit is 1, the register number is pointer bits 4:0.
- R3: After reset, registers 2, 3, 4, 5, 18 and 19 read 0x88. Registers 6 and 7 read 0x80, register 9 reads 0x08, register 12 reads 0x8A, and registers 25 and 26 read 0xA0. Every other indirect register reads 0x00.
- R4: Writes to registers 11, 22, 27 and 29 are discarded.
- R5: In register 12 only bit 6 takes the written value. A write to register 9 stores the data with bit 5 forced to 0.
- R6: A write to register 8 is stored in full when MCE is 1. When MCE is 0 and bit 4 of register 24 is 1, bits 7:4 come from the write and bits 3:0 keep their old value. When both are 0, the write is dropped.
- R7: A pointer write that takes MCE from 0 to 1 while register 9 bits 4:3 are non-zero loads a calibration count of CAL_READS (default 1). While the count is non-zero, each read of register 11 returns bit 5 set and lowers the count by one. When the count is zero, register 11 reads its stored value.
- R8: Any write to address 2 clears status bit 0, clears bits 6:4 of register 24, and drops `irq`.
- R9: A write to register 24 that takes its bit 4 from 1 to 0 clears status bit 0 and drops `irq`. A write that leaves bit 4 at 1 does not.
- R10: A one-cycle `dma_irq_set` pulse sets status bit 0 and bit 4 of register 24. If a clear lands in the same cycle, the set wins.
- R11: Address 2 reads {7'b0, INT}, and `irq` equals INT. Address 3 reads 0x00, and writes to it have no effect.
- R12: `rate_fmt`, `iface_cfg` and `pin_ctl` show registers 8, 9 and 10. `play_count` shows {register 14, register 15}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Port select |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed port (combinational) |
| dma_irq_set | input | 1 | Playback-count-done pulse from the DMA engine |
| irq | output | 1 | Interrupt level |
| rate_fmt | output | 8 | Register 8 contents |
| iface_cfg | output | 8 | Register 9 contents |
| pin_ctl | output | 8 | Register 10 contents |
| play_count | output | 16 | Registers 14 and 15 |

## Verification
The hardest state to reach is the calibration flag. It appears only after a specific sequence: MCE must first be cleared, then set again, while register 9 still has a non-zero bit in 4:3. The flag then has to be read through a pointer aimed at register 11. The stimulus rewrites the pointer without MCE and then with it, and reads register 11 until the flag lapses. The same steps are repeated with register 9 cleared, to show that no count is loaded. Same-cycle set/clear collisions on the interrupt are also driven directly by asserting `dma_irq_set` together with a status-port write.

// File: rtl/codec_regif_pkg.sv
package codec_regif_pkg;

    localparam int NUM_IND = 32;
    localparam int IND_W   = $clog2(NUM_IND);

    typedef enum logic [1:0] {
        PORT_INDEX  = 2'd0,
        PORT_DATA   = 2'd1,
        PORT_STATUS = 2'd2,
        PORT_PIO    = 2'd3
    } port_e;

    localparam logic [IND_W-1:0] IX_FMT     = 5'd8;
    localparam logic [IND_W-1:0] IX_IFACE   = 5'd9;
    localparam logic [IND_W-1:0] IX_PIN     = 5'd10;
    localparam logic [IND_W-1:0] IX_ERR     = 5'd11;
    localparam logic [IND_W-1:0] IX_MODE    = 5'd12;
    localparam logic [IND_W-1:0] IX_CNT_HI  = 5'd14;
    localparam logic [IND_W-1:0] IX_CNT_LO  = 5'd15;
    localparam logic [IND_W-1:0] IX_RSV_A   = 5'd22;
    localparam logic [IND_W-1:0] IX_ALTSTAT = 5'd24;
    localparam logic [IND_W-1:0] IX_RSV_B   = 5'd27;
    localparam logic [IND_W-1:0] IX_RSV_C   = 5'd29;

    localparam int MODE2_BIT = 6;
    localparam int PI_BIT    = 4;

    // Default contents of each indirect register after reset.
    function automatic logic [7:0] ind_reset(input int n);
        case (n)
            2, 3, 4, 5, 18, 19: return 8'h88;
            6, 7:               return 8'h80;
            9:                  return 8'h08;
            12:                 return 8'h8A;
            25, 26:             return 8'hA0;
            default:            return 8'h00;
        endcase
    endfunction

    function automatic logic is_locked(input logic [IND_W-1:0] sel);
        return (sel == IX_ERR) || (sel == IX_RSV_A) ||
               (sel == IX_RSV_B) || (sel == IX_RSV_C);
    endfunction

endpackage

// File: rtl/regif_index.sv
module regif_index
    import codec_regif_pkg::*;
#(
    parameter int CAL_READS = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ptr_wr,
    input  logic [7:0]       wdata,
    input  logic             mode2,
    input  logic             cal_en,
    input  logic             err_read,
    output logic [6:0]       ptr_q,
    output logic [IND_W-1:0] ind_sel,
    output logic             cal_busy
);
    localparam int CNT_W = $clog2(CAL_READS + 1);

    logic [CNT_W-1:0] cal_cnt;

    assign ind_sel  = mode2 ? ptr_q[IND_W-1:0] : {1'b0, ptr_q[3:0]};
    assign cal_busy = (cal_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= 7'h40;
            cal_cnt <= '0;
        end else if (ptr_wr) begin
            ptr_q <= wdata[6:0];
            if (!ptr_q[6] && wdata[6] && cal_en)
                cal_cnt <= CNT_W'(CAL_READS);
        end else if (err_read && cal_busy) begin
            cal_cnt <= cal_cnt - 1'b1;
        end
    end

    // R7: each flagged read of the error register consumes one count
    assert_cal_step_R7: assert property (@(posedge clk) disable iff (rst)
        (err_read && cal_busy && !ptr_wr) |=> (cal_cnt == $past(cal_cnt) - 1'b1));

    // R7: no load without a rising MCE
    assert_cal_noload_R7: assert property (@(posedge clk) disable iff (rst)
        (!cal_busy && !(ptr_wr && wdata[6] && !ptr_q[6])) |=> !cal_busy);

endmodule

// File: rtl/regif_file.sv
module regif_file
    import codec_regif_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             data_wr,
    input  logic             status_wr,
    input  logic             irq_set,
    input  logic [IND_W-1:0] ind_sel,
    input  logic [7:0]       wdata,
    input  logic             mce,
    output logic [7:0]       rd_value,
    output logic             mode2,
    output logic             cal_en,
    output logic             pi_drop,
    output logic [7:0]       rate_fmt,
    output logic [7:0]       iface_cfg,
    output logic [7:0]       pin_ctl,
    output logic [15:0]      play_count
);
    logic [7:0] regs [NUM_IND];
    logic [7:0] wval;
    logic       wkeep;
    logic [7:0] alt_next;

    // Per-register write rules
    always_comb begin
        wval  = wdata;
        wkeep = is_locked(ind_sel);
        case (ind_sel)
            IX_MODE:  wval = {regs[IX_MODE][7], wdata[MODE2_BIT], regs[IX_MODE][5:0]};
            IX_IFACE: wval = {wdata[7:6], 1'b0, wdata[4:0]};
            IX_FMT: begin
                if (mce)
                    wval = wdata;
                else if (regs[IX_ALTSTAT][PI_BIT])
                    wval = {wdata[7:4], regs[IX_FMT][3:0]};
                else
                    wkeep = 1'b1;
            end
            default: ;
        endcase
    end

    // Alternate status register: host write, status clear, DMA set (set last)
    always_comb begin
        alt_next = regs[IX_ALTSTAT];
        if (data_wr && ind_sel == IX_ALTSTAT)
            alt_next = wdata;
        if (status_wr)
            alt_next = alt_next & 8'h8F;
        if (irq_set)
            alt_next[PI_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < NUM_IND; n++)
                regs[n] <= ind_reset(n);
        end else begin
            for (int n = 0; n < NUM_IND; n++)
                if (data_wr && !wkeep && ind_sel == IND_W'(n))
                    regs[n] <= wval;
            regs[IX_ALTSTAT] <= alt_next;
        end
    end

    assign rd_value   = regs[ind_sel];
    assign mode2      = regs[IX_MODE][MODE2_BIT];
    assign cal_en     = (regs[IX_IFACE][4:3] != 2'b00);
    assign pi_drop    = data_wr && (ind_sel == IX_ALTSTAT) &&
                        regs[IX_ALTSTAT][PI_BIT] && !wdata[PI_BIT];
    assign rate_fmt   = regs[IX_FMT];
    assign iface_cfg  = regs[IX_IFACE];
    assign pin_ctl    = regs[IX_PIN];
    assign play_count = {regs[IX_CNT_HI], regs[IX_CNT_LO]};

    // R4: read-only and reserved registers hold through writes
    assert_err_ro_R4: assert property (@(posedge clk) disable iff (rst)
        (data_wr && ind_sel == IX_ERR) |=> $stable(regs[IX_ERR]));
    assert_rsv_R4: assert property (@(posedge clk) disable iff (rst)
        (data_wr && ind_sel == IX_RSV_A) |=> $stable(regs[IX_RSV_A]));

    // R5: only the mode bit of register 12 moves
    assert_mode_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (data_wr && ind_sel == IX_MODE) |=>
        ((regs[IX_MODE] & 8'hBF) == $past(regs[IX_MODE] & 8'hBF)));

    // R6: format write without any enable is dropped
    assert_fmt_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (data_wr && ind_sel == IX_FMT && !mce && !regs[IX_ALTSTAT][PI_BIT])
        |=> $stable(regs[IX_FMT]));

    // R10: DMA set always lands in the alternate status register
    assert_pi_set_R10: assert property (@(posedge clk) disable iff (rst)
        irq_set |=> regs[IX_ALTSTAT][PI_BIT]);

endmodule

// File: rtl/regif_irq.sv
module regif_irq (
    input  logic clk,
    input  logic rst,
    input  logic irq_set,
    input  logic status_wr,
    input  logic pi_drop,
    output logic int_q
);
    always_ff @(posedge clk) begin
        if (rst)
            int_q <= 1'b0;
        else if (irq_set)
            int_q <= 1'b1;
        else if (status_wr || pi_drop)
            int_q <= 1'b0;
    end

    // R10: the set wins over any same-cycle clear
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        irq_set |=> int_q);

    // R8: a status write with no set drops the level
    assert_status_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (status_wr && !irq_set) |=> !int_q);

    // R9: the PI drop clears the level
    assert_pi_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (pi_drop && !irq_set) |=> !int_q);

endmodule

// File: rtl/codec_regif.sv
module codec_regif
    import codec_regif_pkg::*;
#(
    parameter int CAL_READS = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        dma_irq_set,
    output logic        irq,
    output logic [7:0]  rate_fmt,
    output logic [7:0]  iface_cfg,
    output logic [7:0]  pin_ctl,
    output logic [15:0] play_count
);
    port_e             port;
    logic [6:0]        ptr_q;
    logic [IND_W-1:0]  ind_sel;
    logic              cal_busy;
    logic              mode2;
    logic              cal_en;
    logic              pi_drop;
    logic              int_q;
    logic [7:0]        file_rd;
    logic              ptr_wr;
    logic              data_wr;
    logic              status_wr;
    logic              err_read;

    assign port      = port_e'(bus_addr);
    assign ptr_wr    = bus_wr && (port == PORT_INDEX);
    assign data_wr   = bus_wr && (port == PORT_DATA);
    assign status_wr = bus_wr && (port == PORT_STATUS);
    assign err_read  = bus_rd && (port == PORT_DATA) && (ind_sel == IX_ERR);

    regif_index #(.CAL_READS(CAL_READS)) index_i (
        .clk      (clk),
        .rst      (rst),
        .ptr_wr   (ptr_wr),
        .wdata    (bus_wdata),
        .mode2    (mode2),
        .cal_en   (cal_en),
        .err_read (err_read),
        .ptr_q    (ptr_q),
        .ind_sel  (ind_sel),
        .cal_busy (cal_busy)
    );

    regif_file file_i (
        .clk        (clk),
        .rst        (rst),
        .data_wr    (data_wr),
        .status_wr  (status_wr),
        .irq_set    (dma_irq_set),
        .ind_sel    (ind_sel),
        .wdata      (bus_wdata),
        .mce        (ptr_q[6]),
        .rd_value   (file_rd),
        .mode2      (mode2),
        .cal_en     (cal_en),
        .pi_drop    (pi_drop),
        .rate_fmt   (rate_fmt),
        .iface_cfg  (iface_cfg),
        .pin_ctl    (pin_ctl),
        .play_count (play_count)
    );

    regif_irq irq_i (
        .clk       (clk),
        .rst       (rst),
        .irq_set   (dma_irq_set),
        .status_wr (status_wr),
        .pi_drop   (pi_drop),
        .int_q     (int_q)
    );

    always_comb begin
        case (port)
            PORT_INDEX:  bus_rdata = {1'b0, ptr_q};
            PORT_DATA:   bus_rdata = file_rd |
                                     ((ind_sel == IX_ERR && cal_busy) ? 8'h20 : 8'h00);
            PORT_STATUS: bus_rdata = {7'b0, int_q};
            default:     bus_rdata = 8'h00;
        endcase
    end

    assign irq = int_q;

    // R1: pointer port bit 7 never reads back set
    assert_ptr_b7_R1: assert property (@(posedge clk) disable iff (rst)
        (port == PORT_INDEX) |-> !bus_rdata[7]);

    // R11: status port mirrors the interrupt level
    assert_status_irq_R11: assert property (@(posedge clk) disable iff (rst)
        (port == PORT_STATUS) |-> (bus_rdata[0] == irq));

endmodule

// File: tb/codec_regif_tb_top.sv
module codec_regif_tb_top;
    localparam int CAL = 1;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  bus_addr;
    logic        bus_wr;
    logic        bus_rd;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        dma_irq_set;
    logic        irq;
    logic [7:0]  rate_fmt;
    logic [7:0]  iface_cfg;
    logic [7:0]  pin_ctl;
    logic [15:0] play_count;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // behavioural reference state
    int m_reg [32];
    int m_ptr;
    int m_cnt;
    int m_int;

    always #10 clk = ~clk;

    codec_regif #(.CAL_READS(CAL)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .dma_irq_set(dma_irq_set),
        .irq        (irq),
        .rate_fmt   (rate_fmt),
        .iface_cfg  (iface_cfg),
        .pin_ctl    (pin_ctl),
        .play_count (play_count)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic void m_reset();
        for (int n = 0; n < 32; n++) m_reg[n] = 0;
        foreach (m_reg[n])
            if (n inside {2, 3, 4, 5, 18, 19}) m_reg[n] = 'h88;
        m_reg[6] = 'h80; m_reg[7] = 'h80; m_reg[9] = 'h08; m_reg[12] = 'h8A;
        m_reg[25] = 'hA0; m_reg[26] = 'hA0;
        m_ptr = 'h40; m_cnt = 0; m_int = 0;
    endfunction

    function automatic int m_sel();
        return ((m_reg[12] & 'h40) != 0) ? (m_ptr & 31) : (m_ptr & 15);
    endfunction

    function automatic int m_read(input int a);
        int v;
        case (a)
            0: return m_ptr;
            1: begin
                v = m_reg[m_sel()];
                if (m_sel() == 11 && m_cnt > 0) v = v | 'h20;
                return v;
            end
            2: return m_int;
            default: return 0;
        endcase
    endfunction

    function automatic void m_step(input int a, input bit wr, input bit rd, input int d, input bit set);
        int i;
        i = m_sel();
        if (wr && a == 0) begin
            if ((m_ptr & 'h40) == 0 && (d & 'h40) != 0 && (m_reg[9] & 'h18) != 0) m_cnt = CAL;
            m_ptr = d & 'h7F;
        end else if (rd && a == 1 && i == 11 && m_cnt > 0) begin
            m_cnt = m_cnt - 1;
        end
        if (wr && a == 1) begin
            if (i == 12) m_reg[12] = (m_reg[12] & 'hBF) | (d & 'h40);
            else if (i == 9) m_reg[9] = d & 'hDF;
            else if (i == 8) begin
                if ((m_ptr & 'h40) != 0) m_reg[8] = d;
                else if ((m_reg[24] & 'h10) != 0) m_reg[8] = (d & 'hF0) | (m_reg[8] & 'h0F);
            end else if (i == 24) begin
                if ((m_reg[24] & 'h10) != 0 && (d & 'h10) == 0) m_int = 0;
                m_reg[24] = d;
            end else if (!(i inside {11, 22, 27, 29})) m_reg[i] = d;
        end
        if (wr && a == 2) begin
            m_int = 0;
            m_reg[24] = m_reg[24] & 'h8F;
        end
        if (set) begin
            m_int = 1;
            m_reg[24] = m_reg[24] | 'h10;
        end
    endfunction

    // one bus cycle; outputs compared against the model every clock
    task automatic cyc(input int a, input bit wr, input bit rd, input int d, input bit set, input string req);
        @(negedge clk);
        bus_addr = 2'(a); bus_wr = wr; bus_rd = rd; bus_wdata = 8'(d); dma_irq_set = set;
        #2;
        if (rd) chk(req, "rdata", int'(bus_rdata), m_read(a));
        @(posedge clk);
        m_step(a, wr, rd, d, set);
        #2;
        bus_wr = 0; bus_rd = 0; dma_irq_set = 0;
        chk("R11", "irq", int'(irq), m_int);
        chk("R12", "rate_fmt", int'(rate_fmt), m_reg[8]);
        chk("R12", "iface_cfg", int'(iface_cfg), m_reg[9]);
        chk("R12", "pin_ctl", int'(pin_ctl), m_reg[10]);
        chk("R12", "play_count", int'(play_count), m_reg[14] * 256 + m_reg[15]);
    endtask

    task automatic ind_wr(input int idx, input int d, input string req);
        cyc(0, 1, 0, idx, 0, req);
        cyc(1, 1, 0, d, 0, req);
        cyc(1, 0, 1, 0, 0, req);
    endtask

    initial begin
        rst = 1; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0; dma_irq_set = 0;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        cyc(0, 0, 1, 0, 0, "R1");                       // pointer reset value
        for (int k = 0; k < 16; k++) begin              // narrow window defaults
            cyc(0, 1, 0, k, 0, "R3");
            cyc(1, 0, 1, 0, 0, "R3");
        end
        cyc(0, 1, 0, 'h1A, 0, "R2");                    // aliasing in narrow mode
        cyc(1, 0, 1, 0, 0, "R2");
        ind_wr('h0C, 'hFF, "R5");                       // only mode bit moves
        for (int k = 0; k < 32; k++) begin              // wide window defaults
            cyc(0, 1, 0, k, 0, "R2");
            cyc(1, 0, 1, 0, 0, "R3");
        end
        cyc(0, 1, 0, 'hFF, 0, "R1");
        cyc(0, 0, 1, 0, 0, "R1");                       // bit 7 reads 0
        ind_wr('h16, 'h5A, "R4");
        ind_wr('h1B, 'h5A, "R4");
        ind_wr('h1D, 'h5A, "R4");
        ind_wr('h0B, 'h5A, "R4");
        ind_wr('h49, 'hFF, "R5");                       // bit 5 forced low
        ind_wr('h18, 'h00, "R6");
        ind_wr('h08, 'h37, "R6");                       // dropped
        ind_wr('h18, 'h10, "R6");
        ind_wr('h08, 'hA5, "R6");                       // upper nibble only
        ind_wr('h48, 'h5C, "R6");                       // full write
        cyc(0, 1, 0, 'h0B, 0, "R7");
        cyc(0, 1, 0, 'h4B, 0, "R7");                    // MCE rise loads count
        cyc(1, 0, 1, 0, 0, "R7");
        cyc(1, 0, 1, 0, 0, "R7");
        cyc(1, 0, 1, 0, 0, "R7");
        ind_wr('h49, 'h00, "R7");
        cyc(0, 1, 0, 'h0B, 0, "R7");
        cyc(0, 1, 0, 'h4B, 0, "R7");                    // no load
        cyc(1, 0, 1, 0, 0, "R7");
        ind_wr('h0E, 'h12, "R12");
        ind_wr('h0F, 'h34, "R12");
        ind_wr('h0A, 'h02, "R12");
        ind_wr('h18, 'h00, "R10");
        cyc(0, 0, 0, 0, 1, "R10");
        cyc(2, 0, 1, 0, 0, "R11");
        cyc(1, 0, 1, 0, 0, "R10");
        ind_wr('h18, 'h70, "R8");
        cyc(2, 1, 0, 'h00, 0, "R8");
        cyc(1, 0, 1, 0, 0, "R8");
        cyc(2, 0, 1, 0, 0, "R8");
        cyc(0, 0, 0, 0, 1, "R9");
        ind_wr('h18, 'h30, "R9");                       // bit 4 stays, no clear
        ind_wr('h18, 'h00, "R9");                       // falling bit 4 clears
        cyc(2, 1, 0, 'h00, 1, "R10");                   // set beats clear
        cyc(2, 0, 1, 0, 0, "R10");
        cyc(0, 0, 0, 0, 1, "R10");
        ind_wr('h18, 'h00, "R10");                      // set and drop together
        cyc(0, 1, 0, 'h18, 0, "R10");
        cyc(1, 1, 0, 'h00, 1, "R10");
        cyc(1, 0, 1, 0, 0, "R10");
        cyc(3, 1, 0, 'hAA, 0, "R11");
        cyc(3, 0, 1, 0, 0, "R11");
        cyc(0, 0, 1, 0, 0, "R11");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule